// File: doc/BRIEF.md
# Hibernate wakeup and reset sequencer

This block sits beside a real-time clock in the always-on domain and sequences a hibernate cycle. Software writes a one to the hibernate trigger register, and the block drives a power-down output that switches off the main supply domain. While hibernating it watches an external wakeup pin. The pin is first brought into the slow clock domain through a two-flop synchronizer, then debounced by a counter. A wakeup counts only once the pin has stayed high for a programmed number of slow-clock ticks. A shorter pulse sends the block back to waiting.

After a valid wakeup the block releases power-down and holds an active-low reset for a second programmed number of ticks. It then returns to the active state. Both timing fields hold only the bits from bit 5 upward, so each step of either field is 32 ticks. A write-ready output shows when the three registers accept writes. This is only the case in the active state.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset, pwr_down_o is 0, rst_no is 1 and reg_ready_o is 1. Both timing fields are 0.
- R2: A write at offset 0x20 with wdata bit 0 set, made while ready, raises pwr_down_o from the next cycle on. The same write with bit 0 clear has no effect.
- R3: A write at offset 0x24 loads the filter length F = wdata[15:5] * 32 ticks. Bits 4:0 and 31:16 are ignored.
- R4: A write at offset 0x28 loads the reset length R = wdata[11:5] * 32 ticks. Bits 4:0 and 31:12 are ignored.
- R5: The wakeup pin passes through two synchronizer flops. If the pin is raised while hibernating and held, pwr_down_o falls exactly 3 + F clock cycles after the pin rises.
- R6: The wakeup is accepted only if the pin stays high for F + 1 consecutive cycles. A pulse of F cycles returns the block to hibernate, with pwr_down_o still 1 and rst_no still 1.
- R7: rst_no goes low in the same cycle that pwr_down_o falls and stays low for exactly R cycles. The block is then active again with reg_ready_o at 1. With R = 0, no reset pulse occurs.
- R8: reg_ready_o is 0 whenever the block is not active. Writes made while it is 0 change no register and start nothing.
- R9: With F = 0, the first sampled assertion of the synchronized pin is accepted.
- R10: pwr_down_o is never 1 while rst_no is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_ready_o | output | 1 | Registers accept writes |
| wake_pin_i | input | 1 | Asynchronous wakeup pin, active high |
| pwr_down_o | output | 1 | Power-down request to the supply switches |
| rst_no | output | 1 | Active-low reset to the woken domain |

## Verification
The bench sweeps filter codes 0 to 2 against reset codes 0, 1 and 3. For each pair it measures how long the pin takes to release power-down and how long the reset stays low. This separates an off-by-one in the synchronizer depth from one in either counter. Pin pulses of exactly F and F + 1 cycles fix the filter boundary from both sides. Writes with every ignored bit set show that only the masked field is kept. A reprogramming attempt made while hibernating must leave the measured latency at its old value.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_HIB     = 2'd1,
    ST_FILT    = 2'd2,
    ST_RSTHOLD = 2'd3
  } hws_state_e;
endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hws_regs.sv
module hws_regs #(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 32,
  parameter int          LSB      = 5,
  parameter int          FILT_W   = 11,
  parameter int          RST_W    = 7,
  parameter logic [5:0]  HIB_OFS  = 6'h20,
  parameter logic [5:0]  FILT_OFS = 6'h24,
  parameter logic [5:0]  RST_OFS  = 6'h28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic              hib_req_o,
  output logic [FILT_W-1:0] filt_code_o,
  output logic [RST_W-1:0]  rst_code_o
);
  logic wr_ok;
  logic unused_wdata;

  assign wr_ok        = we_i && ready_i;
  assign hib_req_o    = wr_ok && (addr_i == ADDR_W'(HIB_OFS)) && wdata_i[0];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_code_o <= '0;
      rst_code_o  <= '0;
    end else if (wr_ok) begin
      if (addr_i == ADDR_W'(FILT_OFS)) filt_code_o <= wdata_i[LSB +: FILT_W];
      if (addr_i == ADDR_W'(RST_OFS))  rst_code_o  <= wdata_i[LSB +: RST_W];
    end
  end

  // R8: registers frozen while sequencing
  p_frozen_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ($stable(filt_code_o) && $stable(rst_code_o)));
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
  import hws_pkg::*;
#(
  parameter int LSB    = 5,
  parameter int FILT_W = 11,
  parameter int RST_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hib_req_i,
  input  logic              wake_i,
  input  logic [FILT_W-1:0] filt_code_i,
  input  logic [RST_W-1:0]  rst_code_i,
  output logic              active_o,
  output logic              pwr_down_o,
  output logic              rst_no
);
  localparam int CW    = (FILT_W > RST_W) ? FILT_W : RST_W;
  localparam int CNT_W = CW + LSB;

  hws_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] filt_ticks, rst_ticks, filt_last, rst_last;
  hws_state_e after_wake;

  assign filt_ticks = CNT_W'({filt_code_i, {LSB{1'b0}}});
  assign rst_ticks  = CNT_W'({rst_code_i,  {LSB{1'b0}}});
  assign filt_last  = filt_ticks - 1'b1;
  assign rst_last   = rst_ticks - 1'b1;
  assign after_wake = (rst_ticks == '0) ? ST_ACTIVE : ST_RSTHOLD;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:  if (hib_req_i) state_d = ST_HIB;
      ST_HIB:     if (wake_i) state_d = (filt_ticks == '0) ? after_wake : ST_FILT;
      ST_FILT: begin
        if (!wake_i)                 state_d = ST_HIB;
        else if (cnt_q == filt_last) state_d = after_wake;
      end
      ST_RSTHOLD: if (cnt_q == rst_last) state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
    cnt_d = ((state_d == state_q) && (state_q == ST_FILT || state_q == ST_RSTHOLD))
            ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o   = (state_q == ST_ACTIVE);
  assign pwr_down_o = (state_q == ST_HIB) || (state_q == ST_FILT);
  assign rst_no     = (state_q != ST_RSTHOLD);

  p_enter_hib_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && hib_req_i) |=> pwr_down_o);
  p_stay_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !hib_req_i) |=> active_o);
  p_glitch_back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILT && !wake_i) |=> (state_q == ST_HIB));
  p_filt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILT) |-> (cnt_q < filt_ticks));
  p_hold_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RSTHOLD) |-> (cnt_q < rst_ticks));
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_down_o && !rst_no));
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LSB    = 5,
  parameter int FILT_W = 11,
  parameter int RST_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              reg_ready_o,
  input  logic              wake_pin_i,
  output logic              pwr_down_o,
  output logic              rst_no
);
  logic              wake_s, hib_req, active;
  logic [FILT_W-1:0] filt_code;
  logic [RST_W-1:0]  rst_code;

  hws_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wake_pin_i), .q_o(wake_s)
  );

  hws_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LSB(LSB), .FILT_W(FILT_W), .RST_W(RST_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .ready_i(active), .hib_req_o(hib_req),
    .filt_code_o(filt_code), .rst_code_o(rst_code)
  );

  hws_fsm #(.LSB(LSB), .FILT_W(FILT_W), .RST_W(RST_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .hib_req_i(hib_req), .wake_i(wake_s),
    .filt_code_i(filt_code), .rst_code_i(rst_code), .active_o(active),
    .pwr_down_o(pwr_down_o), .rst_no(rst_no)
  );

  assign reg_ready_o = active;
endmodule

// File: tb/tb_hib_wake_seq.sv
`timescale 1ns/1ps
module tb_hib_wake_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        reg_ready_o, wake_pin_i, pwr_down_o, rst_no;
  int checks = 0, fails = 0;

  initial wake_pin_i = 1'b0;
  always #5 clk_i = ~clk_i;

  hib_wake_seq dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  // Pin held high; returns measured latency and reset low length
  task automatic wake_measure(output int lat, output int rlen, output int rst_seen);
    lat = 0; rlen = 0; rst_seen = 0;
    wake_pin_i = 1'b1;
    while (pwr_down_o && lat < 70000) begin
      @(negedge clk_i); lat++;
      if (!rst_no && pwr_down_o) rst_seen = 1;
    end
    while (!rst_no && rlen < 70000) begin
      rlen++; @(negedge clk_i);
    end
    wake_pin_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run_case(input int fc, input int rc, input logic [31:0] fdirt,
                          input logic [31:0] rdirt);
    int lat, rlen, bad;
    int f = fc * 32, r = rc * 32;
    wr(6'h24, (32'(fc) << 5) | fdirt);
    wr(6'h28, (32'(rc) << 5) | rdirt);
    wr(6'h20, 32'h1);
    chk("R2 pwr_down after trigger", pwr_down_o, 1);
    chk("R8 ready low in hibernate", reg_ready_o, 0);
    repeat (4) @(negedge clk_i);
    chk("R2 still down", pwr_down_o, 1);
    wake_measure(lat, rlen, bad);
    chk($sformatf("R5 R3 R9 latency f=%0d", f), lat, 3 + f);
    chk($sformatf("R7 R4 reset len r=%0d", r), rlen, r);
    chk("R10 no overlap", bad, 0);
    chk("R7 ready after", reg_ready_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL R5 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat, rlen, bad;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 pwr_down", pwr_down_o, 0);
    chk("R1 rst_no", rst_no, 1);
    chk("R1 ready", reg_ready_o, 1);

    // R2: trigger with bit0 clear is ignored
    wr(6'h20, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk_i);
    chk("R2 bit0 clear ignored", pwr_down_o, 0);

    // sweep
    for (int fc = 0; fc < 3; fc++)
      for (int rc = 0; rc < 4; rc++)
        if (rc != 2) run_case(fc, rc, 32'h0, 32'h0);

    // R3 R4: ignored bits
    run_case(1, 2, 32'hFFFF_001F, 32'hFFFF_F01F);

    // R6: pulse boundary with F=64
    wr(6'h24, 32'd2 << 5);
    wr(6'h28, 32'd1 << 5);
    wr(6'h20, 32'h1);
    wake_pin_i = 1'b1;
    repeat (64) @(negedge clk_i);
    wake_pin_i = 1'b0;
    repeat (80) @(negedge clk_i);
    chk("R6 pulse F rejected pwr", pwr_down_o, 1);
    chk("R6 pulse F rejected rst", rst_no, 1);
    wake_pin_i = 1'b1;
    repeat (65) @(negedge clk_i);
    wake_pin_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R6 pulse F+1 accepted", pwr_down_o, 0);
    repeat (40) @(negedge clk_i);
    chk("R7 active after pulse", reg_ready_o, 1);

    // R8: writes while hibernating ignored
    wr(6'h24, 32'd1 << 5);
    wr(6'h28, 32'd0);
    wr(6'h20, 32'h1);
    wr(6'h24, 32'd0);
    wr(6'h28, 32'd3 << 5);
    wr(6'h20, 32'h1);
    wake_measure(lat, rlen, bad);
    chk("R8 filter unchanged", lat, 3 + 32);
    chk("R8 reset len unchanged", rlen, 0);
    chk("R10 no overlap", bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule